// File: doc/BRIEF.md
# Frame Sync Output Generator

This block produces the frame synchronisation level for one side of a synchronous serial port. It runs on the bit clock. Each cycle it reads a 3-bit shape selector, a pulse length made of a 4-bit low part and a 4-bit high part, an 8-bit period value, an edge-polarity select and two strobes that mark the start and the end of a data transfer. From these it drives the sync pin level and its output enable, and it issues a periodic one-cycle frame start pulse.

The frame start pulse can be fed back as the start event of the shape generator, so a continuous stream of frames needs no external start strobe. A separate detector watches the sync pin as an input and reports edges of the selected polarity, for use when another device owns the frame sync. Data shifting, the pin tristate buffer and register access are outside this block.

Top module: `fsync_gen`

## Requirements
- R1: Shape codes 0, 6 and 7 drive nothing: one cycle after such a code is applied `fs_oe` is 0 and `fs_out` is 0, and start strobes have no effect on either. Codes 1 to 5 set `fs_oe` to 1 one cycle after they are applied.
- R2: Shape code 1 (low pulse): idle level is 1; a start strobe sampled at a clock edge drives `fs_out` to 0 from that edge for exactly (length + 1) cycles, then back to 1.
- R3: Shape code 2 (high pulse): idle level is 0; a start strobe gives a high level for exactly (length + 1) cycles.
- R4: The pulse length is `{len_ext, len_base}`: `len_ext` forms bits 7..4 and `len_base` bits 3..0, so ext=1, base=1 gives 18 cycles of pulse.
- R5: Shape code 3 drives 0 from the edge that samples a start strobe until the edge that samples an end strobe, and 1 otherwise; shape code 4 is the same with levels swapped.
- R6: Shape code 5 inverts `fs_out` at every edge that samples a start strobe; the toggle state is 0 after reset or while disabled.
- R7: With period 0, or with `en` low, `frame_start` stays 0.
- R8: With period P > 0, after `en` rises `frame_start` is a one-cycle pulse at the 2(P+1)-th enabled edge and every 2(P+1) edges after it.
- R9: With `self_trig` high, each `frame_start` pulse acts as a start strobe on the next edge, so the shape begins one cycle after the pulse.
- R10: `fs_pin_in` passes through a two-stage synchronizer; `edge_hit` is a one-cycle pulse two cycles after the pin changes, for a rise when `edge_sel` is 0 and a fall when `edge_sel` is 1, and stays 0 for the other direction.
- R11: Reset, or `en` low, cancels any pulse or level and puts `fs_out` at the idle level of the current shape one cycle later (1 for codes 1 and 3, 0 otherwise).
- R12: A start strobe arriving while a pulse is in progress restarts the count, so the pulse ends (length + 1) cycles after the later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low acts as a soft reset to idle |
| mode | input | 3 | Output shape selector |
| len_base | input | 4 | Pulse length, low bits |
| len_ext | input | 4 | Pulse length, high bits |
| period | input | 8 | Frame period value; 0 turns periodic frames off |
| edge_sel | input | 1 | Input edge polarity: 0 rising, 1 falling |
| fs_pin_in | input | 1 | Sampled sync pin level (asynchronous) |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_end | input | 1 | Transfer end strobe |
| self_trig | input | 1 | Use `frame_start` as the start event |
| fs_out | output | 1 | Sync pin level to drive |
| fs_oe | output | 1 | Sync pin output enable |
| frame_start | output | 1 | Periodic frame start pulse |
| edge_hit | output | 1 | Selected edge seen on the sync pin |

## Verification
The bench builds the block with its default widths: a 4-bit low and 4-bit high length part and an 8-bit period. These make both ends of each range reachable in a short run: a length of 18 cycles shows the high part's weight, and a period of 255 gives a 512-cycle frame that exercises the counter's top bit alongside short periods of 1 and 2 and the off value 0.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  localparam logic [2:0] SHAPE_OFF   = 3'd0;
  localparam logic [2:0] SHAPE_NEG   = 3'd1;
  localparam logic [2:0] SHAPE_POS   = 3'd2;
  localparam logic [2:0] SHAPE_LOW   = 3'd3;
  localparam logic [2:0] SHAPE_HIGH  = 3'd4;
  localparam logic [2:0] SHAPE_TOG   = 3'd5;

  // True when the shape code owns the pin.
  function automatic logic shape_drives(logic [2:0] m);
    return (m >= SHAPE_NEG) && (m <= SHAPE_TOG);
  endfunction

  // True for the two counted pulse shapes.
  function automatic logic shape_is_pulse(logic [2:0] m);
    return (m == SHAPE_NEG) || (m == SHAPE_POS);
  endfunction

  // Resting level of each shape; the toggle shape rests at its stored state.
  function automatic logic shape_idle(logic [2:0] m, logic tog);
    logic r;
    case (m)
      SHAPE_NEG, SHAPE_LOW: r = 1'b1;
      SHAPE_TOG:            r = tog;
      default:              r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fsync_period_timer.sv
module fsync_period_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             frame_start
);
  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             running;

  // Frame length 2*(P+1) edges, so the wrap value is 2P+1.
  assign last    = {period, 1'b1};
  assign running = en && (period != '0);

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      cnt         <= '0;
      frame_start <= 1'b0;
    end else if (cnt >= last) begin
      cnt         <= '0;
      frame_start <= 1'b1;
    end else begin
      cnt         <= cnt + CNT_W'(1);
      frame_start <= 1'b0;
    end
  end

  assert_off_no_start_R7: assert property (@(posedge clk) disable iff (rst)
    ((period == '0) || !en) |=> !frame_start);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

endmodule

// File: rtl/fsync_shape.sv
module fsync_shape
  import fsync_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       mode,
  input  logic [LEN_W-1:0] len,
  input  logic             trig,
  input  logic             xfer_end,
  output logic             fs_q,
  output logic             oe_q
);
  logic             active;
  logic [LEN_W-1:0] rem;
  logic             tog;
  logic             idle_lvl;

  assign idle_lvl = shape_idle(mode, tog);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      rem    <= '0;
      tog    <= 1'b0;
      fs_q   <= shape_idle(mode, 1'b0);
      oe_q   <= shape_drives(mode);
    end else begin
      oe_q <= shape_drives(mode);
      case (mode)
        SHAPE_NEG, SHAPE_POS: begin
          if (trig) begin
            active <= 1'b1;
            rem    <= len;
            fs_q   <= ~idle_lvl;
          end else if (active && (rem != '0)) begin
            rem  <= rem - LEN_W'(1);
            fs_q <= ~idle_lvl;
          end else begin
            active <= 1'b0;
            fs_q   <= idle_lvl;
          end
        end
        SHAPE_LOW, SHAPE_HIGH: begin
          if (trig) begin
            active <= 1'b1;
            fs_q   <= ~idle_lvl;
          end else if (xfer_end) begin
            active <= 1'b0;
            fs_q   <= idle_lvl;
          end else begin
            fs_q <= active ? ~idle_lvl : idle_lvl;
          end
        end
        SHAPE_TOG: begin
          if (trig) begin
            tog  <= ~tog;
            fs_q <= ~tog;
          end else begin
            fs_q <= tog;
          end
        end
        default: begin
          active <= 1'b0;
          rem    <= '0;
          fs_q   <= 1'b0;
        end
      endcase
    end
  end

  assert_undriven_R1: assert property (@(posedge clk) disable iff (rst)
    !shape_drives(mode) |=> (!oe_q && !fs_q));

  assert_neg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHAPE_NEG && active && rem != '0 && !trig) |=> !fs_q);

  assert_pos_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHAPE_POS && active && rem != '0 && !trig) |=> fs_q);

  assert_low_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHAPE_LOW && active && !trig && !xfer_end) |=> !fs_q);

  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHAPE_TOG && trig && $past(en && mode == SHAPE_TOG))
      |=> (fs_q != $past(fs_q)));

  assert_disable_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!en && mode == SHAPE_NEG) |=> fs_q);

endmodule

// File: rtl/fsync_edge_det.sv
module fsync_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic edge_sel,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= pin_in;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  logic newer, older;
  assign newer = chain[SYNC_STAGES-2];
  assign older = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) edge_hit <= 1'b0;
    else     edge_hit <= edge_sel ? (older & ~newer) : (~older & newer);
  end

  assert_hit_needs_change_R10: assert property (@(posedge clk) disable iff (rst)
    (newer == older) |=> !edge_hit);

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsync_pkg::*;
#(
  parameter int BASE_W      = 4,
  parameter int EXT_W       = 4,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        mode,
  input  logic [BASE_W-1:0] len_base,
  input  logic [EXT_W-1:0]  len_ext,
  input  logic [PER_W-1:0]  period,
  input  logic              edge_sel,
  input  logic              fs_pin_in,
  input  logic              xfer_start,
  input  logic              xfer_end,
  input  logic              self_trig,
  output logic              fs_out,
  output logic              fs_oe,
  output logic              frame_start,
  output logic              edge_hit
);
  localparam int LEN_W = BASE_W + EXT_W;

  logic [LEN_W-1:0] len;
  logic             trig;

  assign len  = {len_ext, len_base};
  assign trig = xfer_start || (self_trig && frame_start);

  fsync_period_timer #(.PER_W(PER_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .period      (period),
    .frame_start (frame_start)
  );

  fsync_shape #(.LEN_W(LEN_W)) u_shape (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode     (mode),
    .len      (len),
    .trig     (trig),
    .xfer_end (xfer_end),
    .fs_q     (fs_out),
    .oe_q     (fs_oe)
  );

  fsync_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (fs_pin_in),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  assert_self_trig_R9: assert property (@(posedge clk) disable iff (rst)
    (en && self_trig && frame_start && mode == SHAPE_POS) |=> fs_out);

endmodule

// File: tb/sim_fsync_gen.sv
module sim_fsync_gen;
  localparam int CLK_P = 10;
  localparam int S_OUT = 0, S_OE = 1, S_FST = 2, S_EDGE = 3;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst, en, edge_sel, fs_pin_in, xfer_start, xfer_end, self_trig;
  logic [2:0] mode;
  logic [3:0] len_base, len_ext;
  logic [7:0] period;
  logic fs_out, fs_oe, frame_start, edge_hit;

  fsync_gen u0 (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .len_base(len_base),
    .len_ext(len_ext), .period(period), .edge_sel(edge_sel),
    .fs_pin_in(fs_pin_in), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .self_trig(self_trig), .fs_out(fs_out), .fs_oe(fs_oe),
    .frame_start(frame_start), .edge_hit(edge_hit)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    q_cyc[$];
  int    q_sig[$];
  logic  q_val[$];
  string q_req[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Driver side: queue one expected value d edges ahead.
  task automatic want(int d, int sig, logic v, string r);
    q_cyc.push_back(cyc + d);
    q_sig.push_back(sig);
    q_val.push_back(v);
    q_req.push_back(r);
  endtask

  task automatic want_span(int d0, int d1, int sig, logic v, string r);
    for (int d = d0; d <= d1; d++) want(d, sig, v, r);
  endtask

  function automatic logic pick(int sig);
    case (sig)
      S_OUT:   return fs_out;
      S_OE:    return fs_oe;
      S_FST:   return frame_start;
      default: return edge_hit;
    endcase
  endfunction

  // Monitor: compare every queued item due in this cycle.
  always @(posedge clk) begin
    #(CLK_P/4);
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] == cyc) begin
        n_cmp++;
        if (pick(q_sig[i]) !== q_val[i]) begin
          n_bad++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%b expected=%b",
                   q_req[i], q_sig[i], cyc, pick(q_sig[i]), q_val[i]);
        end
        q_cyc.delete(i); q_sig.delete(i); q_val.delete(i); q_req.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_strobe();
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; mode = 3'd0; len_base = '0; len_ext = '0;
    period = '0; edge_sel = 1'b0; fs_pin_in = 1'b0; xfer_start = 1'b0;
    xfer_end = 1'b0; self_trig = 1'b0;
    tick(3);
    // Reset state
    want(1, S_OUT, 1'b0, "R11 reset out");
    want(1, S_OE, 1'b0, "R1 reset oe");
    want(1, S_FST, 1'b0, "R7 reset frame_start");
    tick(1);
    rst = 1'b0; en = 1'b1;
    tick(2);

    // R1: reserved codes ignore start strobes
    mode = 3'd6;
    want_span(1, 3, S_OE, 1'b0, "R1 code6 oe");
    want_span(1, 3, S_OUT, 1'b0, "R1 code6 out");
    start_strobe(); tick(2);
    mode = 3'd7;
    want_span(1, 3, S_OE, 1'b0, "R1 code7 oe");
    want_span(1, 3, S_OUT, 1'b0, "R1 code7 out");
    start_strobe(); tick(2);

    // R2: low pulse, length 2
    mode = 3'd1; len_base = 4'd2; len_ext = 4'd0;
    want(1, S_OE, 1'b1, "R1 code1 oe");
    want(1, S_OUT, 1'b1, "R2 idle high");
    tick(1);
    want_span(1, 3, S_OUT, 1'b0, "R2 low pulse");
    want(4, S_OUT, 1'b1, "R2 pulse end");
    start_strobe(); tick(5);

    // R3: high pulse, length 0
    mode = 3'd2; len_base = 4'd0;
    want(1, S_OUT, 1'b0, "R3 idle low");
    tick(1);
    want(1, S_OUT, 1'b1, "R3 high pulse");
    want(2, S_OUT, 1'b0, "R3 pulse end");
    start_strobe(); tick(3);

    // R4: length {1,1} = 17 -> 18 cycles
    len_base = 4'd1; len_ext = 4'd1;
    want(1, S_OUT, 1'b1, "R4 first");
    want(18, S_OUT, 1'b1, "R4 last");
    want(19, S_OUT, 1'b0, "R4 end");
    start_strobe(); tick(20);

    // R12: retrigger mid-pulse, length 3
    mode = 3'd1; len_base = 4'd3; len_ext = 4'd0;
    tick(1);
    start_strobe(); tick(1);
    want_span(1, 4, S_OUT, 1'b0, "R12 restarted pulse");
    want(5, S_OUT, 1'b1, "R12 end after later strobe");
    start_strobe(); tick(6);

    // R11: disable cancels a pulse
    len_base = 4'd10;
    start_strobe(); tick(2);
    en = 1'b0;
    want(1, S_OUT, 1'b1, "R11 disable to idle");
    tick(1);
    en = 1'b1;
    want_span(1, 3, S_OUT, 1'b1, "R11 stays idle");
    tick(3);

    // R1: code 0 releases pin
    mode = 3'd0;
    want(1, S_OE, 1'b0, "R1 code0 oe");
    want(1, S_OUT, 1'b0, "R1 code0 out");
    tick(2);

    // R5: whole-transfer levels
    mode = 3'd3;
    want(1, S_OUT, 1'b1, "R5 code3 idle");
    tick(1);
    want_span(1, 3, S_OUT, 1'b0, "R5 code3 low");
    start_strobe(); tick(2);
    want(1, S_OUT, 1'b1, "R5 code3 end");
    xfer_end = 1'b1; tick(1); xfer_end = 1'b0;
    want(1, S_OUT, 1'b1, "R5 code3 stays");
    tick(1);
    mode = 3'd4;
    want(1, S_OUT, 1'b0, "R5 code4 idle");
    tick(1);
    want_span(1, 3, S_OUT, 1'b1, "R5 code4 high");
    start_strobe(); tick(2);
    want(1, S_OUT, 1'b0, "R5 code4 end");
    xfer_end = 1'b1; tick(1); xfer_end = 1'b0;
    tick(1);

    // R6: toggle shape
    en = 1'b0; mode = 3'd5;
    tick(1);
    en = 1'b1;
    want(1, S_OUT, 1'b0, "R6 toggle rest 0");
    tick(1);
    want_span(1, 2, S_OUT, 1'b1, "R6 first toggle");
    start_strobe(); tick(1);
    want_span(1, 2, S_OUT, 1'b0, "R6 second toggle");
    start_strobe(); tick(2);

    // R7: period 0 gives no frames
    mode = 3'd0;
    want_span(1, 20, S_FST, 1'b0, "R7 period zero");
    tick(21);

    // R8: period 2 -> every 6 edges
    en = 1'b0; tick(1);
    en = 1'b1; period = 8'd2;
    want(5, S_FST, 1'b0, "R8 before first");
    want(6, S_FST, 1'b1, "R8 first frame");
    want(7, S_FST, 1'b0, "R8 one cycle");
    want(11, S_FST, 1'b0, "R8 gap");
    want(12, S_FST, 1'b1, "R8 second frame");
    tick(13);
    // R8: period 255 -> 512 edges
    en = 1'b0; tick(1);
    en = 1'b1; period = 8'd255;
    want(511, S_FST, 1'b0, "R8 max before");
    want(512, S_FST, 1'b1, "R8 max frame");
    tick(514);

    // R9: frame start triggers a high pulse
    en = 1'b0; mode = 3'd2; len_base = 4'd0; len_ext = 4'd0;
    period = 8'd1; self_trig = 1'b1;
    tick(1);
    en = 1'b1;
    want(3, S_FST, 1'b0, "R9 before frame");
    want(4, S_FST, 1'b1, "R9 frame");
    want(4, S_OUT, 1'b0, "R9 not yet");
    want(5, S_OUT, 1'b1, "R9 shape follows frame");
    want(6, S_OUT, 1'b0, "R9 shape end");
    tick(8);
    en = 1'b0; self_trig = 1'b0; period = 8'd0;
    tick(1);
    en = 1'b1;

    // R10: edge detector
    edge_sel = 1'b0; fs_pin_in = 1'b1;
    want(1, S_EDGE, 1'b0, "R10 sync delay");
    want(2, S_EDGE, 1'b1, "R10 rising seen");
    want(3, S_EDGE, 1'b0, "R10 one cycle");
    tick(4);
    edge_sel = 1'b1; fs_pin_in = 1'b0;
    want(2, S_EDGE, 1'b1, "R10 falling seen");
    want(3, S_EDGE, 1'b0, "R10 falling one cycle");
    tick(4);
    fs_pin_in = 1'b1;
    want_span(1, 4, S_EDGE, 1'b0, "R10 rising ignored");
    tick(6);

    tick(3);
    foreach (q_cyc[i]) begin
      n_cmp++; n_bad++;
      $display("FAIL %s never compared actual=none expected=%b", q_req[i], q_val[i]);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule